// File: doc/BRIEF.md
# Transmit Descriptor Chain Processor

This block walks a ring of four-word transmit descriptors in host memory. It reads word 3 of the descriptor at the current ring index and processes the descriptor only when the device owns it. It then reads the two address words and the control word, and offers one buffer segment per descriptor to a downstream payload fetcher. Per-frame control is taken only from the first-segment descriptor of a frame: checksum insertion mode, VLAN action, frame length, the segmentation offload flag and the auxiliary bit. When the last-segment descriptor has been accepted, the block emits a one-cycle frame-control record and writes back word 3 of every descriptor of the frame, clearing ownership. It then raises a one-cycle interrupt pulse if the last descriptor asked for one.

Broken chains are resolved in place. The frame in progress is aborted, and its descriptors are written back with the error bits set, in three cases: the block meets a host-owned descriptor in the middle of a frame, it meets a new first-segment descriptor before the previous frame ended, or it meets an owned descriptor that is neither part of a frame nor a frame start. The ring base and ring length come from configuration inputs. The memory port is word addressed: descriptor i occupies words base+4i to base+4i+3.

Top module: `txd_chain_walker`

## Requirements
- R1: A descriptor is processed only when bit 31 of its word 3 is 1. While the descriptor at the current index is host owned and no frame is open, the block keeps re-reading that word 3 and emits no segment, no record and no write.
- R2: Writeback writes only word 3, with bit 31 = 0, bit 29 = first-segment, bit 28 = last-segment, bit 23 = descriptor error and bit 15 = error summary, and every other bit 0. A normally completed frame writes 0x3000_0000 for a single-descriptor frame; otherwise it writes 0x2000_0000 on the first descriptor, 0x0000_0000 on middle ones and 0x1000_0000 on the last.
- R3: Checksum mode is word 3 bits 17:16 of the first-segment descriptor (0 none, 1 IP header, 2 header plus payload, 3 header, payload and pseudo-header). The same field on later descriptors of the frame has no effect.
- R4: When word 3 bit 18 of the first descriptor is 1 (segmentation offload), the reported checksum mode is 0, the frame length is word 3 bits 17:0 and segment length 1 is word 2 bits 9:0. Otherwise the frame length is word 3 bits 14:0 and segment length 1 is word 2 bits 13:0.
- R5: The VLAN action (word 2 bits 15:14: 0 none, 1 strip, 2 insert, 3 replace) and the auxiliary bit (word 2 bit 30) are taken from the first descriptor. Segment length 2 is word 2 bits 29:16 of each descriptor.
- R6: Each processed descriptor yields one segment whose address is {word 1, word 0}, with first and last flags copied from word 3 bits 29 and 28. The segment is held stable until it is accepted.
- R7: The frame-control record is a single-cycle pulse after the last segment is accepted. Its interrupt-request field is word 2 bit 31 of the last descriptor.
- R8: Descriptor i is read at word address base+4i+k, and the index wraps to 0 after entry ring_len-1.
- R9: A host-owned descriptor met inside a frame aborts the frame. No record is emitted, the frame's descriptors are written back with bits 23 and 15 set and bit 28 clear, the host-owned descriptor is not written, and the block resumes polling at that descriptor.
- R10: A first-segment descriptor met inside a frame aborts the open frame as in R9 and then starts a new frame at that descriptor.
- R11: An owned descriptor without the first-segment flag met outside a frame yields no segment. It is written back as 0x0080_8000, and processing moves on to the next index.
- R12: The interrupt output pulses for exactly one cycle after the writeback of a completed frame whose last descriptor has word 2 bit 31 set, and not at all otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_ring_base | input | AW | Word address of descriptor 0 |
| cfg_ring_len | input | IW | Number of ring entries (at least 1) |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | AW | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access completes in this cycle |
| seg_valid | output | 1 | Segment offered |
| seg_ready | input | 1 | Segment accepted |
| seg_addr | output | 64 | Buffer address |
| seg_len1 | output | 14 | Buffer-1 length, or header length under offload |
| seg_len2 | output | 14 | Buffer-2 length |
| seg_first | output | 1 | Segment starts a frame |
| seg_last | output | 1 | Segment ends a frame |
| fc_valid | output | 1 | Frame-control record pulse |
| fc_csum | output | 2 | Checksum insertion mode |
| fc_vlan | output | 2 | VLAN action |
| fc_len | output | 18 | Frame length, or payload length under offload |
| fc_tso | output | 1 | Segmentation offload requested |
| fc_aux | output | 1 | Timestamp enable, or external-memory disable under offload |
| fc_irq | output | 1 | Completion interrupt requested |
| irq | output | 1 | Completion interrupt pulse |

## Verification
The bench gives later descriptors of a frame a different checksum code from the first. A design that honoured every descriptor would then report the code of the last one. An offload frame has its length field overlap the checksum bits, so a design that ignored the offload flag would report a non-zero mode and cut the length to 15 bits. The bench also breaks chains in each of the three ways. It checks that the error bits land on the right words, that the host-owned descriptor is left alone and that the next frame still completes; a design that advanced wrongly after an abort would lose or duplicate a descriptor. A short ring with an owned descriptor just past its end shows whether the index really wraps. Memory wait states and segment back-pressure check that requests and segments hold their values.

// File: rtl/txd_pkg.sv
// Shared bit positions, state encoding and the decoded descriptor view
// for the transmit descriptor chain processor.
package txd_pkg;
    localparam int OWN_B = 31;
    localparam int FS_B  = 29;
    localparam int LS_B  = 28;
    localparam int DE_B  = 23;
    localparam int ES_B  = 15;
    localparam int TSO_B = 18;

    typedef enum logic [2:0] {
        S_RD3, S_RD0, S_RD1, S_RD2, S_SEG, S_FC, S_WB, S_IRQ
    } walk_st_t;

    typedef struct packed {
        logic [1:0]  csum;
        logic [1:0]  vlan;
        logic [17:0] flen;
        logic        irq;
        logic        aux;
        logic [13:0] len1;
        logic [13:0] len2;
    } desc_view_t;

    // Writeback form of word 3: ownership returned, flags kept in place.
    function automatic logic [31:0] wb_word(input logic fs, input logic ls,
                                            input logic err);
        logic [31:0] w;
        w       = '0;
        w[FS_B] = fs;
        w[LS_B] = ls;
        w[DE_B] = err;
        w[ES_B] = err;
        return w;
    endfunction
endpackage

// File: rtl/txd_decode.sv
// Field decoder for descriptor words 2 and 3.
// Assumes tso_mode already reflects the frame's offload setting; the
// meaning of the length fields and the checksum field follows it.
module txd_decode
    import txd_pkg::*;
(
    input  logic [31:0] w2,
    input  logic [18:0] w3_lo,
    input  logic        tso_mode,
    output desc_view_t  view
);
    // Split the control words according to the offload mode.
    always_comb begin
        view.csum = tso_mode ? 2'd0 : w3_lo[17:16];
        view.flen = tso_mode ? w3_lo[17:0] : {3'd0, w3_lo[14:0]};
        view.len1 = tso_mode ? {4'd0, w2[9:0]} : w2[13:0];
        view.len2 = w2[29:16];
        view.vlan = w2[15:14];
        view.aux  = w2[30];
        view.irq  = w2[31];
    end
endmodule

// File: rtl/txd_ring_addr.sv
// Ring address generator: word address of a descriptor word and the
// wrapped successor index. Assumes len >= 1 and AW >= IW + 2.
module txd_ring_addr #(
    parameter int AW = 16,
    parameter int IW = 6
) (
    input  logic [AW-1:0] base,
    input  logic [IW-1:0] len,
    input  logic [IW-1:0] idx,
    input  logic [1:0]    word,
    output logic [AW-1:0] addr,
    output logic [IW-1:0] idx_nxt
);
    localparam int SW = IW + 2;

    // Four words per descriptor, index wraps after the last entry.
    always_comb begin
        addr    = base + AW'({idx, 2'b00}) + AW'(word);
        idx_nxt = (idx == len - 1'b1) ? '0 : idx + 1'b1;
    end

    if (SW > AW) begin : g_bad_width
        initial $display("txd_ring_addr: AW too small for IW");
    end
endmodule

// File: rtl/txd_chain_walker.sv
// Transmit descriptor chain processor.
// Polls word 3 of the current descriptor; owned descriptors are read in
// full and offered as segments; per-frame control is latched from the
// first-segment descriptor. After the last segment a control record is
// pulsed and word 3 of every descriptor of the frame is written back.
// Assumes a word-addressed memory that completes an access when mem_ack
// is high during mem_req, with read data valid in that cycle.
module txd_chain_walker
    import txd_pkg::*;
#(
    parameter int AW = 16,
    parameter int IW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] cfg_ring_base,
    input  logic [IW-1:0] cfg_ring_len,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    input  logic          mem_ack,
    output logic          seg_valid,
    input  logic          seg_ready,
    output logic [63:0]   seg_addr,
    output logic [13:0]   seg_len1,
    output logic [13:0]   seg_len2,
    output logic          seg_first,
    output logic          seg_last,
    output logic          fc_valid,
    output logic [1:0]    fc_csum,
    output logic [1:0]    fc_vlan,
    output logic [17:0]   fc_len,
    output logic          fc_tso,
    output logic          fc_aux,
    output logic          fc_irq,
    output logic          irq
);
    walk_st_t    st;
    logic [IW-1:0] idx, fstart, wb_end, idx_nxt;
    logic        in_frame, abort, had_fs, irq_last;
    logic [31:0] w0_q, w1_q, w2_q;
    logic [18:0] w3_lo;
    logic        w3_fs, w3_ls;
    logic [1:0]  word_sel;
    logic        tso_mode;
    desc_view_t  view;

    txd_decode u_dec (
        .w2       (w2_q),
        .w3_lo    (w3_lo),
        .tso_mode (tso_mode),
        .view     (view)
    );

    txd_ring_addr #(.AW(AW), .IW(IW)) u_addr (
        .base    (cfg_ring_base),
        .len     (cfg_ring_len),
        .idx     (idx),
        .word    (word_sel),
        .addr    (mem_addr),
        .idx_nxt (idx_nxt)
    );

    // Offload mode: own bit on a frame start, the frame's bit afterwards.
    assign tso_mode = w3_fs ? w3_lo[TSO_B] : fc_tso;

    // Memory port driven from the state.
    always_comb begin
        mem_req  = (st == S_RD3) || (st == S_RD0) || (st == S_RD1) ||
                   (st == S_RD2) || (st == S_WB);
        mem_we   = (st == S_WB);
        unique case (st)
            S_RD0:   word_sel = 2'd0;
            S_RD1:   word_sel = 2'd1;
            S_RD2:   word_sel = 2'd2;
            default: word_sel = 2'd3;
        endcase
        mem_wdata = wb_word(had_fs && (idx == fstart),
                            !abort && (idx == wb_end), abort);
    end

    // Segment and pulse outputs.
    always_comb begin
        seg_valid = (st == S_SEG);
        seg_addr  = {w1_q, w0_q};
        seg_len1  = view.len1;
        seg_len2  = view.len2;
        seg_first = w3_fs;
        seg_last  = w3_ls;
        fc_valid  = (st == S_FC);
        irq       = (st == S_IRQ);
    end

    // Descriptor walk, frame bookkeeping and writeback sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= S_RD3;  idx <= '0;  fstart <= '0;  wb_end <= '0;
            in_frame <= 1'b0;  abort <= 1'b0;  had_fs <= 1'b0;
            irq_last <= 1'b0;
            w0_q <= '0;  w1_q <= '0;  w2_q <= '0;
            w3_lo <= '0;  w3_fs <= 1'b0;  w3_ls <= 1'b0;
            fc_csum <= '0;  fc_vlan <= '0;  fc_len <= '0;
            fc_tso <= 1'b0;  fc_aux <= 1'b0;  fc_irq <= 1'b0;
        end else begin
            unique case (st)
                S_RD3: if (mem_ack) begin
                    w3_lo <= mem_rdata[18:0];
                    w3_fs <= mem_rdata[FS_B];
                    w3_ls <= mem_rdata[LS_B];
                    if (in_frame && (!mem_rdata[OWN_B] || mem_rdata[FS_B])) begin
                        abort <= 1'b1;
                        idx   <= fstart;
                        st    <= S_WB;
                    end else if (mem_rdata[OWN_B] && !mem_rdata[FS_B] && !in_frame) begin
                        abort  <= 1'b1;
                        had_fs <= 1'b0;
                        fstart <= idx;
                        wb_end <= idx;
                        st     <= S_WB;
                    end else if (mem_rdata[OWN_B]) begin
                        if (mem_rdata[FS_B]) begin
                            fstart   <= idx;
                            had_fs   <= 1'b1;
                            in_frame <= 1'b1;
                        end
                        st <= S_RD0;
                    end
                end
                S_RD0: if (mem_ack) begin w0_q <= mem_rdata; st <= S_RD1; end
                S_RD1: if (mem_ack) begin w1_q <= mem_rdata; st <= S_RD2; end
                S_RD2: if (mem_ack) begin w2_q <= mem_rdata; st <= S_SEG; end
                S_SEG: if (seg_ready) begin
                    wb_end   <= idx;
                    irq_last <= view.irq;
                    if (w3_fs) begin
                        fc_csum <= view.csum;
                        fc_vlan <= view.vlan;
                        fc_len  <= view.flen;
                        fc_tso  <= w3_lo[TSO_B];
                        fc_aux  <= view.aux;
                    end
                    if (w3_ls) begin
                        fc_irq <= view.irq;
                        st     <= S_FC;
                    end else begin
                        idx <= idx_nxt;
                        st  <= S_RD3;
                    end
                end
                S_FC: begin
                    abort <= 1'b0;
                    idx   <= fstart;
                    st    <= S_WB;
                end
                S_WB: if (mem_ack) begin
                    idx <= idx_nxt;
                    if (idx == wb_end) begin
                        in_frame <= 1'b0;
                        st <= (!abort && irq_last) ? S_IRQ : S_RD3;
                    end
                end
                S_IRQ: st <= S_RD3;
                default: st <= S_RD3;
            endcase
        end
    end
endmodule

// File: rtl/txd_chain_walker_chk.sv
// Protocol checker for txd_chain_walker, attached by bind.
module txd_chain_walker_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] cfg_ring_base,
    input logic          mem_req,
    input logic          mem_we,
    input logic          mem_ack,
    input logic [AW-1:0] mem_addr,
    input logic [31:0]   mem_wdata,
    input logic          seg_valid,
    input logic          seg_ready,
    input logic [63:0]   seg_addr,
    input logic          fc_valid,
    input logic          fc_tso,
    input logic [1:0]    fc_csum,
    input logic          irq
);
    logic [AW-1:0] off;
    assign off = mem_addr - cfg_ring_base;

    // R8: an access is held unchanged until acknowledged
    a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    // R2: writeback returns ownership and touches only the status bits
    a_r2_wb_format: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> !mem_wdata[31] && ((mem_wdata & ~32'h3080_8000) == 32'd0));

    // R2: writeback goes to word 3 only
    a_r2_wb_word3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> off[1:0] == 2'b11);

    // R6: an offered segment holds until accepted
    a_r6_seg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid && !seg_ready |=> seg_valid && $stable(seg_addr));

    // R7: the record is a single-cycle pulse, never alongside a segment
    a_r7_fc_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        fc_valid |=> !fc_valid);
    a_r7_fc_alone: assert property (@(posedge clk) disable iff (!rst_n)
        fc_valid |-> !seg_valid && !mem_req);

    // R4: offload frames never report a checksum mode
    a_r4_tso_nocsum: assert property (@(posedge clk) disable iff (!rst_n)
        fc_valid && fc_tso |-> fc_csum == 2'd0);

    // R12: the interrupt is a single-cycle pulse
    a_r12_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
endmodule

bind txd_chain_walker txd_chain_walker_chk #(.AW(AW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_ring_base (cfg_ring_base),
    .mem_req       (mem_req),
    .mem_we        (mem_we),
    .mem_ack       (mem_ack),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata),
    .seg_valid     (seg_valid),
    .seg_ready     (seg_ready),
    .seg_addr      (seg_addr),
    .fc_valid      (fc_valid),
    .fc_tso        (fc_tso),
    .fc_csum       (fc_csum),
    .irq           (irq)
);

// File: tb/txd_chain_walker_bench.sv
// Directed bench: one task per scenario, each checking its own results.
module txd_chain_walker_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int IW = 6;
    localparam int BASE = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] cfg_ring_base = AW'(BASE);
    logic [IW-1:0] cfg_ring_len = IW'(4);
    logic mem_req, mem_we, mem_ack;
    logic [AW-1:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata;
    logic seg_valid, seg_first, seg_last;
    logic seg_ready = 1'b1;
    logic [63:0] seg_addr;
    logic [13:0] seg_len1, seg_len2;
    logic fc_valid, fc_tso, fc_aux, fc_irq, irq;
    logic [1:0] fc_csum, fc_vlan;
    logic [17:0] fc_len;

    txd_chain_walker #(.AW(AW), .IW(IW)) u_txd_chain_walker (
        .clk(clk), .rst_n(rst_n), .cfg_ring_base(cfg_ring_base),
        .cfg_ring_len(cfg_ring_len), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack), .seg_valid(seg_valid), .seg_ready(seg_ready),
        .seg_addr(seg_addr), .seg_len1(seg_len1), .seg_len2(seg_len2),
        .seg_first(seg_first), .seg_last(seg_last), .fc_valid(fc_valid),
        .fc_csum(fc_csum), .fc_vlan(fc_vlan), .fc_len(fc_len),
        .fc_tso(fc_tso), .fc_aux(fc_aux), .fc_irq(fc_irq), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Memory model with a host write port and optional wait states.
    logic [31:0] mem [0:255];
    logic h_we = 1'b0, mem_clr = 1'b0, stall_mode = 1'b0, ack_gate = 1'b1;
    logic [7:0] h_addr = '0;
    logic [31:0] h_data = '0;
    int dev_wr_cnt;

    assign mem_rdata = mem[mem_addr[7:0]];
    assign mem_ack   = mem_req & ack_gate;

    always @(posedge clk) begin
        if (mem_clr) begin
            for (int i = 0; i < 256; i++) mem[i] <= '0;
            dev_wr_cnt <= 0;
        end else begin
            if (h_we) mem[h_addr] <= h_data;
            if (mem_req && mem_we && mem_ack) begin
                mem[mem_addr[7:0]] <= mem_wdata;
                dev_wr_cnt <= dev_wr_cnt + 1;
            end
        end
    end

    always @(negedge clk) ack_gate <= stall_mode ? ~ack_gate : 1'b1;

    // Output monitor, sampled on the falling edge.
    int seg_cnt, fc_cnt, irq_cnt;
    logic [63:0] s_addr [0:7];
    logic [13:0] s_len1 [0:7];
    logic [13:0] s_len2 [0:7];
    logic        s_first [0:7];
    logic        s_last [0:7];
    logic [1:0]  r_csum, r_vlan;
    logic [17:0] r_len;
    logic        r_tso, r_aux, r_irq;
    logic [7:0]  irq_probe = '0;
    logic [31:0] irq_w3;

    always @(negedge clk) begin
        if (!rst_n) begin
            seg_cnt = 0; fc_cnt = 0; irq_cnt = 0; irq_w3 = '1;
        end else begin
            if (seg_valid && seg_ready) begin
                s_addr[seg_cnt % 8]  = seg_addr;
                s_len1[seg_cnt % 8]  = seg_len1;
                s_len2[seg_cnt % 8]  = seg_len2;
                s_first[seg_cnt % 8] = seg_first;
                s_last[seg_cnt % 8]  = seg_last;
                seg_cnt++;
            end
            if (fc_valid) begin
                r_csum = fc_csum; r_vlan = fc_vlan; r_len = fc_len;
                r_tso = fc_tso; r_aux = fc_aux; r_irq = fc_irq;
                fc_cnt++;
            end
            if (irq) begin
                irq_cnt++;
                irq_w3 = mem[irq_probe];
            end
        end
    end

    int tests = 0, fails = 0;
    bit done = 1'b0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int addr, input logic [31:0] data);
        @(negedge clk);
        h_we = 1'b1; h_addr = 8'(addr); h_data = data;
        @(posedge clk);
        #1 h_we = 1'b0;
    endtask

    function automatic int w3a(input int i);
        return BASE + 4 * i + 3;
    endfunction

    task automatic put_desc(input int i, input logic [31:0] d0, input logic [31:0] d1,
                            input logic [31:0] d2, input logic [31:0] d3);
        wr(BASE + 4 * i, d0);
        wr(BASE + 4 * i + 1, d1);
        wr(BASE + 4 * i + 2, d2);
        wr(BASE + 4 * i + 3, d3);
    endtask

    task automatic do_reset(input int len);
        @(negedge clk);
        rst_n = 1'b0; mem_clr = 1'b1; cfg_ring_len = IW'(len);
        stall_mode = 1'b0; seg_ready = 1'b1;
        repeat (2) @(negedge clk);
        mem_clr = 1'b0; rst_n = 1'b1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        do_reset(4);
        chk("R1 reset seg_valid", 64'(seg_valid), 64'd0);
        chk("R7 reset fc_valid", 64'(fc_valid), 64'd0);
        chk("R12 reset irq", 64'(irq), 64'd0);
        idle(30);
        chk("R8 poll address", 64'(mem_addr), 64'(w3a(0)));
        chk("R1 no segment on host-owned", 64'(seg_cnt), 64'd0);
        chk("R1 no write on host-owned", 64'(dev_wr_cnt), 64'd0);
    endtask

    task automatic t_single;
        do_reset(4);
        irq_probe = 8'(w3a(0));
        put_desc(0, 32'hAAAA_0010, 32'h0000_0001, 32'hC123_8040, 32'hB003_0064);
        idle(40);
        chk("R6 seg addr", s_addr[0], 64'h0000_0001_AAAA_0010);
        chk("R4 seg len1", 64'(s_len1[0]), 64'h40);
        chk("R5 seg len2", 64'(s_len2[0]), 64'h123);
        chk("R6 seg flags", {62'd0, s_first[0], s_last[0]}, 64'd3);
        chk("R7 one record", 64'(fc_cnt), 64'd1);
        chk("R3 csum", 64'(r_csum), 64'd3);
        chk("R5 vlan", 64'(r_vlan), 64'd2);
        chk("R4 len", 64'(r_len), 64'd100);
        chk("R5 aux", 64'(r_aux), 64'd1);
        chk("R7 fc_irq", 64'(r_irq), 64'd1);
        chk("R2 wb single", 64'(mem[w3a(0)]), 64'h3000_0000);
        chk("R12 irq pulse count", 64'(irq_cnt), 64'd1);
        chk("R12 irq after writeback", 64'(irq_w3[31]), 64'd0);
    endtask

    task automatic t_multi;
        do_reset(4);
        stall_mode = 1'b1;
        put_desc(2, 32'h0000_0300, 32'h0, 32'h0000_C030, 32'h9002_0007);
        put_desc(1, 32'h0000_0200, 32'h0, 32'h0005_0020, 32'h8003_0055);
        put_desc(0, 32'h0000_0100, 32'h0, 32'h8000_4010, 32'hA001_012C);
        idle(120);
        chk("R6 three segments", 64'(seg_cnt), 64'd3);
        chk("R3 later csum ignored", 64'(r_csum), 64'd1);
        chk("R5 vlan from first", 64'(r_vlan), 64'd1);
        chk("R4 len from first", 64'(r_len), 64'd300);
        chk("R6 middle addr", s_addr[1], 64'h200);
        chk("R5 middle len2", 64'(s_len2[1]), 64'd5);
        chk("R6 flags first", {62'd0, s_first[0], s_last[0]}, 64'd2);
        chk("R6 flags last", {62'd0, s_first[2], s_last[2]}, 64'd1);
        chk("R2 wb first", 64'(mem[w3a(0)]), 64'h2000_0000);
        chk("R2 wb middle", 64'(mem[w3a(1)]), 64'h0000_0000);
        chk("R2 wb last", 64'(mem[w3a(2)]), 64'h1000_0000);
        chk("R12 no irq when last has none", 64'(irq_cnt), 64'd0);
        chk("R7 fc_irq from last", 64'(r_irq), 64'd0);
    endtask

    task automatic t_tso;
        do_reset(4);
        put_desc(0, 32'h0000_0400, 32'h0, 32'hC000_3ABC, 32'hB006_1234);
        idle(40);
        chk("R4 tso flag", 64'(r_tso), 64'd1);
        chk("R4 csum suppressed", 64'(r_csum), 64'd0);
        chk("R4 payload len", 64'(r_len), 64'h2_1234);
        chk("R4 header len", 64'(s_len1[0]), 64'h2BC);
        chk("R12 irq tso", 64'(irq_cnt), 64'd1);
    endtask

    task automatic t_backpressure;
        do_reset(4);
        seg_ready = 1'b0;
        put_desc(0, 32'h0000_0500, 32'h0000_0002, 32'h0000_0010, 32'hB000_0010);
        idle(40);
        chk("R6 held valid", 64'(seg_valid), 64'd1);
        chk("R6 held addr", seg_addr, 64'h0000_0002_0000_0500);
        chk("R7 no record before accept", 64'(fc_cnt), 64'd0);
        seg_ready = 1'b1;
        idle(20);
        chk("R6 accepted once", 64'(seg_cnt), 64'd1);
        chk("R7 record after accept", 64'(fc_cnt), 64'd1);
    endtask

    task automatic t_abort_owned;
        do_reset(4);
        put_desc(0, 32'h0000_0600, 32'h0, 32'h0000_0010, 32'hA001_0020);
        idle(40);
        chk("R9 no record", 64'(fc_cnt), 64'd0);
        chk("R9 segment before abort", 64'(seg_cnt), 64'd1);
        chk("R9 wb error", 64'(mem[w3a(0)]), 64'h2080_8000);
        chk("R9 host desc untouched", 64'(mem[w3a(1)]), 64'd0);
        chk("R9 one write", 64'(dev_wr_cnt), 64'd1);
        put_desc(1, 32'h0000_0700, 32'h0, 32'h0000_0010, 32'h9000_0010);
        idle(30);
        chk("R11 orphan wb", 64'(mem[w3a(1)]), 64'h0080_8000);
        chk("R11 orphan no segment", 64'(seg_cnt), 64'd1);
        put_desc(2, 32'h0000_0800, 32'h0, 32'h0000_0010, 32'hB000_0010);
        idle(30);
        chk("R11 moves on", 64'(fc_cnt), 64'd1);
        chk("R11 next segment addr", s_addr[1], 64'h800);
    endtask

    task automatic t_abort_fs;
        do_reset(4);
        put_desc(1, 32'h0000_0900, 32'h0, 32'h0000_0010, 32'hB002_0032);
        put_desc(0, 32'h0000_0A00, 32'h0, 32'h0000_0010, 32'hA001_003C);
        idle(60);
        chk("R10 old frame error", 64'(mem[w3a(0)]), 64'h2080_8000);
        chk("R10 new frame wb", 64'(mem[w3a(1)]), 64'h3000_0000);
        chk("R10 one record", 64'(fc_cnt), 64'd1);
        chk("R10 new csum", 64'(r_csum), 64'd2);
        chk("R10 new len", 64'(r_len), 64'd50);
        chk("R10 two segments", 64'(seg_cnt), 64'd2);
    endtask

    task automatic t_wrap;
        do_reset(3);
        put_desc(3, 32'h0000_DEAD, 32'h0, 32'h0000_0010, 32'hB000_0010);
        put_desc(0, 32'h0000_0100, 32'h0, 32'h0000_0010, 32'hB000_0010);
        put_desc(1, 32'h0000_0200, 32'h0, 32'h0000_0010, 32'hB000_0010);
        put_desc(2, 32'h0000_0300, 32'h0, 32'h0000_0010, 32'hB000_0010);
        idle(60);
        put_desc(0, 32'h0000_0400, 32'h0, 32'h0000_0010, 32'hB000_0010);
        idle(40);
        chk("R8 four records", 64'(fc_cnt), 64'd4);
        chk("R8 wrapped addr", s_addr[3], 64'h400);
        chk("R8 beyond ring untouched", 64'(mem[w3a(3)]), 64'hB000_0010);
        chk("R8 wrapped wb", 64'(mem[w3a(0)]), 64'h3000_0000);
    endtask

    initial begin
        t_reset();
        t_single();
        t_multi();
        t_tso();
        t_backpressure();
        t_abort_owned();
        t_abort_fs();
        t_wrap();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule